// File: doc/BRIEF.md
# Match-Frequency Timer with Alarm Channel

This block is a 32-bit up-counter with a power-of-two clock prescaler, intended as a general tick source and one-shot alarm for a processor subsystem. A top-value register sets the wrap point. When the count reaches the top value it returns to zero on the next counting step, so the period is one plus the top value. A second compare register is the only alarm channel. Each match raises a sticky flag. The single interrupt line is the OR of the flags that are enabled.

Software controls the timer through a flat word-addressed register space with single-cycle writes and combinational reads. Run control does not use a plain bit. It goes through a command register that accepts restart, halt and snapshot codes. A snapshot copies the live count into the readable count register. Flags are cleared by writing ones. Enables are changed through separate set and clear addresses, so read-modify-write is never needed. A busy output tells software when a configuration or command write is still being absorbed.

Register map (addr): 0 control (bit 0 enable, bits 3:1 prescale select), 1 command (bits 1:0: 1 restart, 2 halt, 3 snapshot), 2 flags (bit 0 top match, bit 1 alarm match), 3 enable-set, 4 enable-clear (both read back the enable mask), 5 top value, 6 alarm value, 7 count snapshot.

Top module: `tcnt_timer`

## Requirements
- R1: After reset, the top value reads 0xFFFFFFFF. Control, flags, enables and the count register read 0. Interrupt and busy are low.
- R2: Setting the enable bit (control bit 0) leaves the counter stopped at zero until a restart command (code 1) is written.
- R3: A restart command clears the count and starts counting. With prescale select 0 the count rises by one every clock. A restart while running begins again from zero.
- R4: A halt command (code 2) stops the counter and sets its value to zero.
- R5: At a count equal to the top value (address 5), the next counting step gives zero. The top-match flag (flags bit 0) is set in the cycle the count becomes equal to the top.
- R6: If the top is lowered below the current count, the count keeps rising past it and no top-match flag is raised until the count wraps through the full 32-bit range.
- R7: The alarm flag (flags bit 1) is set in the cycle the count becomes equal to the alarm value (address 6).
- R8: Writing a one to a flag bit clears it. Writing zero leaves it unchanged. A flag raised in the same cycle as its clear stays set.
- R9: Writing ones to address 3 enables those sources, and writing ones to address 4 disables them. Zero bits have no effect. The interrupt is high while any flag and its enable are both set.
- R10: With prescale select s, the count advances once every 2^s clocks after a restart.
- R11: A snapshot command (code 3) copies the current count into the count register (address 7). The register then holds that value until the next snapshot.
- R12: Busy is high for exactly two cycles after a write to control, command, top or alarm. Writes to flags or enable addresses do not raise it.
- R13: While the enable bit is clear, command writes are ignored. In particular, a snapshot leaves the count register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 3 | Register word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Interrupt: any enabled flag set |
| busy | output | 1 | Write or command still propagating |

## Verification
The assertions assume that wr_en is a clean single-cycle strobe with addr and wdata stable around the rising edge. They also assume the top and alarm values do not change in the same cycle as the match that the flag checks examine; those checks exclude such cycles explicitly. The stimulus drives all inputs on the falling edge, issues one write per cycle, and reads only at idle falling edges. It starts every scenario from a fresh reset, so each expected count is a simple function of cycles since the restart.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  localparam int ADDR_W     = 3;
  localparam int NUM_FLAGS  = 2;
  localparam int FLAG_TOP   = 0;
  localparam int FLAG_ALARM = 1;
  localparam int CMD_W      = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_CMD    = 3'd1,
    REG_FLAGS  = 3'd2,
    REG_IE_SET = 3'd3,
    REG_IE_CLR = 3'd4,
    REG_TOP    = 3'd5,
    REG_ALARM  = 3'd6,
    REG_COUNT  = 3'd7
  } reg_addr_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE    = 2'd0,
    CMD_RESTART = 2'd1,
    CMD_HALT    = 2'd2,
    CMD_SNAP    = 2'd3
  } cmd_e;
endpackage

// File: rtl/tcnt_prescaler.sv
module tcnt_prescaler #(
  parameter int PS_SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                clear,
  input  logic [PS_SEL_W-1:0] sel,
  output logic                tick
);
  localparam int PRE_W = (1 << PS_SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = (PRE_W'(1) << sel) - PRE_W'(1);
    tick = run && ((pre_q & mask) == mask);
    if (clear || !run) pre_d = '0;
    else               pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              halt,
  input  logic              tick,
  input  logic [DATA_W-1:0] top,
  input  logic [DATA_W-1:0] alarm,
  output logic [DATA_W-1:0] count,
  output logic              running,
  output logic              hit_top,
  output logic              hit_alarm
);
  logic [DATA_W-1:0] cnt_q, cnt_d, cnt_step;
  logic              run_q, run_d;
  logic              adv;
  logic              cnt_en;

  always_comb begin
    cnt_step  = (cnt_q == top) ? '0 : cnt_q + DATA_W'(1);
    adv       = run_q && tick && !restart && !halt;
    hit_top   = adv && (cnt_step == top);
    hit_alarm = adv && (cnt_step == alarm);
    cnt_en    = restart || halt || adv;
    run_d     = run_q;
    cnt_d     = cnt_q;
    if (restart) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (halt) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/tcnt_regs.sv
module tcnt_regs
  import tcnt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PS_SEL_W    = 3,
  parameter int BUSY_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_FLAGS-1:0] flag_set,
  input  logic [DATA_W-1:0]    count,
  output logic [DATA_W-1:0]    rdata,
  output logic                 enable,
  output logic [PS_SEL_W-1:0]  ps_sel,
  output logic [DATA_W-1:0]    top,
  output logic [DATA_W-1:0]    alarm,
  output logic                 cmd_restart,
  output logic                 cmd_halt,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] ie,
  output logic                 busy
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int CTRL_W = PS_SEL_W + 1;

  logic wr_ctrl, wr_cmd, wr_flags, wr_ie_set, wr_ie_clr, wr_top, wr_alarm;
  cmd_e cmd_code;
  logic snap_load, busy_load;

  logic                 en_q;
  logic [PS_SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0]    top_q, alarm_q, snap_q;
  logic [NUM_FLAGS-1:0] flags_q, flags_d, flag_clr;
  logic [NUM_FLAGS-1:0] ie_q, ie_d;
  logic [BUSY_W-1:0]    busy_q, busy_d;

  always_comb begin
    wr_ctrl   = wr_en && (addr == REG_CTRL);
    wr_cmd    = wr_en && (addr == REG_CMD);
    wr_flags  = wr_en && (addr == REG_FLAGS);
    wr_ie_set = wr_en && (addr == REG_IE_SET);
    wr_ie_clr = wr_en && (addr == REG_IE_CLR);
    wr_top    = wr_en && (addr == REG_TOP);
    wr_alarm  = wr_en && (addr == REG_ALARM);
    cmd_code  = cmd_e'(wdata[CMD_W-1:0]);
  end

  always_comb begin
    cmd_restart = wr_cmd && en_q && (cmd_code == CMD_RESTART);
    snap_load   = wr_cmd && en_q && (cmd_code == CMD_SNAP);
    cmd_halt    = (wr_cmd && en_q && (cmd_code == CMD_HALT)) ||
                  (wr_ctrl && (wdata[0] != en_q));
    busy_load   = wr_ctrl || wr_cmd || wr_top || wr_alarm;
  end

  always_comb begin
    flag_clr = wr_flags ? wdata[NUM_FLAGS-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
    ie_d     = ie_q;
    if (wr_ie_set) ie_d = ie_q | wdata[NUM_FLAGS-1:0];
    if (wr_ie_clr) ie_d = ie_q & ~wdata[NUM_FLAGS-1:0];
    if (busy_load)            busy_d = BUSY_W'(BUSY_CYCLES);
    else if (busy_q != '0)    busy_d = busy_q - BUSY_W'(1);
    else                      busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      top_q   <= '1;
      alarm_q <= '0;
      snap_q  <= '0;
      flags_q <= '0;
      ie_q    <= '0;
      busy_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[0];
        sel_q <= wdata[PS_SEL_W:1];
      end
      if (wr_top)    top_q   <= wdata;
      if (wr_alarm)  alarm_q <= wdata;
      if (snap_load) snap_q  <= count;
      flags_q <= flags_d;
      ie_q    <= ie_d;
      busy_q  <= busy_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      REG_CTRL:   rdata[CTRL_W-1:0]    = {sel_q, en_q};
      REG_CMD:    rdata                = '0;
      REG_FLAGS:  rdata[NUM_FLAGS-1:0] = flags_q;
      REG_IE_SET: rdata[NUM_FLAGS-1:0] = ie_q;
      REG_IE_CLR: rdata[NUM_FLAGS-1:0] = ie_q;
      REG_TOP:    rdata                = top_q;
      REG_ALARM:  rdata                = alarm_q;
      REG_COUNT:  rdata                = snap_q;
      default:    rdata                = '0;
    endcase
  end

  assign enable = en_q;
  assign ps_sel = sel_q;
  assign top    = top_q;
  assign alarm  = alarm_q;
  assign flags  = flags_q;
  assign ie     = ie_q;
  assign busy   = (busy_q != '0);
endmodule

// File: rtl/tcnt_timer.sv
module tcnt_timer
  import tcnt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PS_SEL_W    = 3,
  parameter int BUSY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              busy
);
  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  logic                 enable, running, tick;
  logic [PS_SEL_W-1:0]  ps_sel;
  logic [DATA_W-1:0]    top, alarm, count;
  logic                 cmd_restart, cmd_halt;
  logic                 hit_top, hit_alarm;
  logic [NUM_FLAGS-1:0] flag_set, flags, ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_TOP]   = hit_top;
    flag_set[FLAG_ALARM] = hit_alarm;
  end

  tcnt_regs #(
    .DATA_W(DATA_W), .PS_SEL_W(PS_SEL_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flag_set(flag_set), .count(count), .rdata(rdata), .enable(enable),
    .ps_sel(ps_sel), .top(top), .alarm(alarm), .cmd_restart(cmd_restart),
    .cmd_halt(cmd_halt), .flags(flags), .ie(ie), .busy(busy)
  );

  tcnt_prescaler #(.PS_SEL_W(PS_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(enable && running),
    .clear(cmd_restart), .sel(ps_sel), .tick(tick)
  );

  tcnt_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .restart(cmd_restart), .halt(cmd_halt),
    .tick(tick), .top(top), .alarm(alarm), .count(count), .running(running),
    .hit_top(hit_top), .hit_alarm(hit_alarm)
  );

  assign irq = |(flags & ie);
endmodule

// File: rtl/tcnt_timer_chk.sv
module tcnt_timer_chk
  import tcnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic                 tick,
  input logic                 running,
  input logic [DATA_W-1:0]    count,
  input logic [DATA_W-1:0]    top,
  input logic [DATA_W-1:0]    alarm,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] ie,
  input logic                 busy
);
  logic en_cmd_wr, ctl_wr;
  assign en_cmd_wr = wr_en && (addr == REG_CMD);
  assign ctl_wr    = wr_en && (addr == REG_CTRL);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> count == '0);  // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd_wr && wdata[1:0] == CMD_RESTART && running) |=> (count == '0 && running));  // R3
  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count == top && !en_cmd_wr && !ctl_wr) |=> count == '0);  // R5
  AST_TOP_FLAG_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[FLAG_TOP]) && !$past(wr_en && addr == REG_TOP)) |-> count == top);  // R5
  AST_ALARM_FLAG_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[FLAG_ALARM]) && !$past(wr_en && addr == REG_ALARM)) |-> count == alarm);  // R7
  AST_IE_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_IE_SET) |=> ((ie & $past(wdata[NUM_FLAGS-1:0])) == $past(wdata[NUM_FLAGS-1:0])));  // R9
  AST_IE_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_IE_CLR) |=> ((ie & $past(wdata[NUM_FLAGS-1:0])) == '0));  // R9
  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd_wr || ctl_wr) |=> busy);  // R12
endmodule

bind tcnt_timer tcnt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tick(tick), .running(running), .count(count), .top(top), .alarm(alarm),
  .flags(flags), .ie(ie), .busy(busy)
);

// File: tb/tcnt_timer_bench.sv
`timescale 1ns/1ps
module tcnt_timer_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_CMD = 3'd1, A_FLAGS = 3'd2, A_IES = 3'd3,
                         A_IEC = 3'd4, A_TOP = 3'd5, A_ALARM = 3'd6, A_COUNT = 3'd7;
  localparam logic [31:0] C_RESTART = 32'd1, C_HALT = 32'd2, C_SNAP = 32'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, busy;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tcnt_timer u_tcnt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic snap_chk(input string req, input logic [31:0] exp);
    logic [31:0] d;
    wr(A_CMD, C_SNAP);
    rd(A_COUNT, d);
    chk(req, d, exp);
  endtask

  task automatic do_reset();
    wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(A_TOP, d);   chk("R1 top", d, 32'hFFFF_FFFF);
    rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
    rd(A_FLAGS, d); chk("R1 flags", d, 0);
    rd(A_IES, d);   chk("R1 ie", d, 0);
    rd(A_COUNT, d); chk("R1 count", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
  endtask

  task automatic t_enable_idle();
    do_reset();
    wr(A_CTRL, 32'd1);
    repeat (6) @(negedge clk);
    snap_chk("R2 no count before restart", 0);
  endtask

  task automatic t_restart();
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_CMD, C_RESTART);
    repeat (5) @(negedge clk);
    snap_chk("R3 count after 5", 5);
    wr(A_CMD, C_RESTART);
    repeat (3) @(negedge clk);
    snap_chk("R3 restart while running", 3);
  endtask

  task automatic t_halt();
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_CMD, C_RESTART);
    repeat (4) @(negedge clk);
    wr(A_CMD, C_HALT);
    repeat (4) @(negedge clk);
    snap_chk("R4 halted at zero", 0);
  endtask

  task automatic t_top();
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_TOP, 32'd5);
    wr(A_CMD, C_RESTART);
    repeat (4) @(negedge clk);
    rd(A_FLAGS, d); chk("R5 no top flag at 4", d, 0);
    @(negedge clk);
    rd(A_FLAGS, d); chk("R5 top flag at 5", d, 32'd1);
    @(negedge clk);
    snap_chk("R5 wrapped to zero", 0);
  endtask

  task automatic t_lower_top();
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_CMD, C_RESTART);
    repeat (20) @(negedge clk);
    wr(A_TOP, 32'd10);
    repeat (30) @(negedge clk);
    rd(A_FLAGS, d); chk("R6 no top flag after lowering", d, 0);
    snap_chk("R6 count passes new top", 51);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_ALARM, 32'd7);
    wr(A_IES, 32'd2);
    wr(A_CMD, C_RESTART);
    repeat (6) @(negedge clk);
    rd(A_FLAGS, d); chk("R7 no alarm at 6", d, 0);
    chk("R9 irq low before alarm", {31'd0, irq}, 0);
    @(negedge clk);
    rd(A_FLAGS, d); chk("R7 alarm at 7", d, 32'd2);
    chk("R9 irq on enabled alarm", {31'd0, irq}, 1);
    wr(A_FLAGS, 32'd0);
    rd(A_FLAGS, d); chk("R8 zero write keeps flag", d, 32'd2);
    wr(A_FLAGS, 32'd2);
    rd(A_FLAGS, d); chk("R8 one write clears flag", d, 0);
    chk("R9 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_ie();
    logic [31:0] d;
    do_reset();
    wr(A_IES, 32'd3); rd(A_IES, d); chk("R9 set both", d, 32'd3);
    wr(A_IEC, 32'd1); rd(A_IEC, d); chk("R9 clear bit0", d, 32'd2);
    wr(A_IES, 32'd0); rd(A_IES, d); chk("R9 zero set no effect", d, 32'd2);
    wr(A_IEC, 32'd0); rd(A_IES, d); chk("R9 zero clear no effect", d, 32'd2);
    wr(A_IEC, 32'd2);
    wr(A_CTRL, 32'd1);
    wr(A_ALARM, 32'd2);
    wr(A_CMD, C_RESTART);
    repeat (3) @(negedge clk);
    rd(A_FLAGS, d); chk("R9 masked flag present", d, 32'd2);
    chk("R9 irq masked", {31'd0, irq}, 0);
    wr(A_IES, 32'd2);
    chk("R9 irq after enable", {31'd0, irq}, 1);
    wr(A_IEC, 32'd2);
    chk("R9 irq after disable", {31'd0, irq}, 0);
  endtask

  task automatic t_prescale();
    do_reset();
    wr(A_CTRL, 32'd5);
    wr(A_CMD, C_RESTART);
    repeat (9) @(negedge clk);
    snap_chk("R10 div4 after 9", 2);
    wr(A_CTRL, 32'd7);
    wr(A_CMD, C_RESTART);
    repeat (17) @(negedge clk);
    snap_chk("R10 div8 after 17", 2);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_CMD, C_RESTART);
    repeat (8) @(negedge clk);
    snap_chk("R11 first snapshot", 8);
    repeat (10) @(negedge clk);
    rd(A_COUNT, d); chk("R11 snapshot held", d, 8);
    snap_chk("R11 second snapshot", 19);
  endtask

  task automatic t_busy();
    do_reset();
    wr(A_CTRL, 32'd1);
    chk("R12 busy cycle 1", {31'd0, busy}, 1);
    @(negedge clk);
    chk("R12 busy cycle 2", {31'd0, busy}, 1);
    @(negedge clk);
    chk("R12 busy done", {31'd0, busy}, 0);
    wr(A_FLAGS, 32'd0);
    chk("R12 flag write no busy", {31'd0, busy}, 0);
    wr(A_IES, 32'd0);
    chk("R12 ie write no busy", {31'd0, busy}, 0);
    wr(A_TOP, 32'd100);
    chk("R12 top write busy", {31'd0, busy}, 1);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_CMD, C_RESTART);
    repeat (6) @(negedge clk);
    snap_chk("R13 setup snapshot", 6);
    wr(A_CTRL, 32'd0);
    wr(A_CMD, C_SNAP);
    rd(A_COUNT, d); chk("R13 snapshot ignored when disabled", d, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_idle();
    t_restart();
    t_halt();
    t_top();
    t_lower_top();
    t_alarm();
    t_ie();
    t_prescale();
    t_snapshot();
    t_busy();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule